// File: doc/BRIEF.md
# Multi-Issue Micro-Op Scheduler Buffer

This block is a circular buffer with 24 entries. It holds decoded micro-operations from the moment they are allocated until they retire. A front end writes a group of one to four operations in program order. Each operation has a class code, a readiness flag and an opaque payload. The buffer sends ready operations to six class-specific execution paths, at most one per path per cycle. Each issued operation carries its entry index as a tag. When that tag comes back on the completion port, the entry is marked finished.

Finished operations leave from the head in strict program order, up to four per cycle. An entry freed by retirement can be handed out again in the same cycle. A flush input discards everything in flight in a single cycle. Readiness can be given at enqueue time, or raised later by a wakeup index.

Top module: `uop_sched_buf`

## Requirements
- R1: After reset the buffer is empty. No issue port and no retire slot is valid, and a group of four is accepted.
- R2: A group is accepted only as a whole, when `in_valid` is high, `flush` is low, `in_count` is at most 4, and `in_count` is no more than the free entries plus the entries retiring in that cycle. Otherwise `in_ready` is low and nothing is written. Slot k of the group uses `in_cls[3k+2:3k]`, `in_rdy[k]` and `in_data[8k+7:8k]`, and slot 0 is the oldest.
- R3: The buffer holds at most 24 operations. With 24 in flight and none retiring, a group of one is refused.
- R4: An entry issues only if it is valid, not yet issued, and ready. Ready comes from `in_rdy` at enqueue, or from a cycle with `wake_valid` high and `wake_idx` naming that valid entry.
- R5: Issue port c serves only class code c: 0 load, 1 store, 2 complex register op, 3 simple register op, 4 floating-point op, 5 branch evaluation. Each port issues at most one operation per cycle, and it picks the oldest eligible entry of its class.
- R6: The issue tag is the entry index. After reset or flush, allocation starts at index 0 and moves upward in program order, wrapping from 23 to 0.
- R7: Each of the six completion lanes whose `cmp_valid` bit is high marks the entry named by its `cmp_idx` field (bits 5j+4:5j) as finished. The retire port shows the payload of each retiring entry, with slot k being the k-th oldest.
- R8: Retirement takes the longest run of finished entries that starts at the head, up to four. `ret_valid` is therefore a contiguous mask from bit 0, and an unfinished head blocks every younger entry.
- R9: Entries that retire in a cycle can be reallocated in that same cycle. A full buffer whose head is retiring accepts a new group.
- R10: When `flush` is high, the cycle shows no issue, no retirement and no acceptance. The next cycle starts from an empty buffer.
- R11: An operation enqueued ready issues no earlier than the next cycle. An entry completed in a cycle retires no earlier than the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all in-flight operations |
| in_valid | input | 1 | Enqueue group present |
| in_count | input | 3 | Number of operations in the group |
| in_cls | input | 12 | Class code per slot, 3 bits each |
| in_rdy | input | 4 | Readiness per slot at enqueue |
| in_data | input | 32 | Payload per slot, 8 bits each |
| in_ready | output | 1 | Whole group can be accepted |
| wake_valid | input | 1 | Wakeup strobe |
| wake_idx | input | 5 | Entry to mark ready |
| iss_valid | output | 6 | Issue valid, one bit per class |
| iss_idx | output | 30 | Issued entry tag per class, 5 bits each |
| iss_data | output | 48 | Issued payload per class, 8 bits each |
| cmp_valid | input | 6 | Completion lane valid |
| cmp_idx | input | 30 | Completed entry tag per lane, 5 bits each |
| ret_valid | output | 4 | Retiring slots, contiguous from bit 0 |
| ret_data | output | 32 | Retiring payloads, oldest in slot 0 |

## Verification
The critical overlap is retirement and allocation landing on the same entries in one cycle. A full buffer whose head is finishing must accept a new group into the slots it is vacating. The bench provokes this in two ways. A directed sequence fills all 24 entries, then wakes, issues and completes the head. A long random run mixes enqueues, wakeups, completions and rare flushes. A behavioural queue model predicts `in_ready`, every issue port and every retire slot each cycle, so that any disagreement about the reused entries' flags, payloads or indices shows up as a mismatch on the next issue or retirement.

// File: rtl/uopq_pkg.sv
`timescale 1ns/1ps
package uopq_pkg;
    localparam int NUM_CLS = 6;
    localparam int CLS_W   = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_LOAD   = 3'd0,
        CLS_STORE  = 3'd1,
        CLS_CPLX   = 3'd2,
        CLS_SIMPLE = 3'd3,
        CLS_FP     = 3'd4,
        CLS_BRANCH = 3'd5
    } op_cls_e;

    typedef struct packed {
        logic    valid;
        logic    issued;
        logic    rdy;
        logic    done;
        op_cls_e cls;
    } slot_flags_t;

    // position a+b on a ring of the given size; a < size, b <= size
    function automatic int ring_add(int a, int b, int size);
        int s;
        s = a + b;
        return (s >= size) ? s - size : s;
    endfunction
endpackage

// File: rtl/uopq_oldest_pick.sv
`timescale 1ns/1ps
module uopq_oldest_pick #(
    parameter int DEPTH = 24,
    parameter int IDX_W = 5
) (
    input  logic [DEPTH-1:0] elig,
    input  logic [IDX_W-1:0] head,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    import uopq_pkg::*;

    // Scan youngest-to-oldest so the last hit written is the oldest.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int off = DEPTH - 1; off >= 0; off--) begin
            if (elig[ring_add(int'(head), off, DEPTH)]) begin
                found = 1'b1;
                idx   = IDX_W'(ring_add(int'(head), off, DEPTH));
            end
        end
    end
endmodule

// File: rtl/uopq_retire_scan.sv
`timescale 1ns/1ps
module uopq_retire_scan #(
    parameter int DEPTH  = 24,
    parameter int GRP    = 4,
    parameter int IDX_W  = 5,
    parameter int GCNT_W = 3
) (
    input  logic [DEPTH-1:0]  fin,
    input  logic [IDX_W-1:0]  head,
    input  logic              block,
    output logic [GRP-1:0]    mask,
    output logic [GCNT_W-1:0] count
);
    import uopq_pkg::*;

    logic run;

    always_comb begin
        run   = !block;
        count = '0;
        for (int k = 0; k < GRP; k++) begin
            run     = run && fin[ring_add(int'(head), k, DEPTH)];
            mask[k] = run;
            if (run) count = count + GCNT_W'(1);
        end
    end
endmodule

// File: rtl/uop_sched_buf.sv
`timescale 1ns/1ps
module uop_sched_buf
    import uopq_pkg::*;
#(
    parameter int DEPTH  = 24,
    parameter int GRP    = 4,
    parameter int DATA_W = 8,
    parameter int CMP_N  = 6,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int GCNT_W = $clog2(GRP + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flush,
    input  logic                        in_valid,
    input  logic [GCNT_W-1:0]           in_count,
    input  logic [GRP*CLS_W-1:0]        in_cls,
    input  logic [GRP-1:0]              in_rdy,
    input  logic [GRP*DATA_W-1:0]       in_data,
    output logic                        in_ready,
    input  logic                        wake_valid,
    input  logic [IDX_W-1:0]            wake_idx,
    output logic [NUM_CLS-1:0]          iss_valid,
    output logic [NUM_CLS*IDX_W-1:0]    iss_idx,
    output logic [NUM_CLS*DATA_W-1:0]   iss_data,
    input  logic [CMP_N-1:0]            cmp_valid,
    input  logic [CMP_N*IDX_W-1:0]      cmp_idx,
    output logic [GRP-1:0]              ret_valid,
    output logic [GRP*DATA_W-1:0]       ret_data
);
    slot_flags_t         ent_q  [DEPTH];
    logic [DATA_W-1:0]   data_q [DEPTH];
    logic [IDX_W-1:0]    head_q, tail_q;
    logic [CNT_W-1:0]    free_q;

    logic [DEPTH-1:0]    vld_vec, isd_vec, rdy_vec, done_vec;
    logic [IDX_W-1:0]    pick_idx [NUM_CLS];
    logic [NUM_CLS-1:0]  pick_found;
    logic [GRP-1:0]      ret_mask;
    logic [GCNT_W-1:0]   ret_n;
    logic                alloc;
    logic [GCNT_W-1:0]   alloc_n;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld_vec[i]  = ent_q[i].valid;
            isd_vec[i]  = ent_q[i].issued;
            rdy_vec[i]  = ent_q[i].rdy;
            done_vec[i] = ent_q[i].valid && ent_q[i].done;
        end
    end

    // per-class oldest-ready selection
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        logic [DEPTH-1:0] elig;
        always_comb begin
            for (int i = 0; i < DEPTH; i++)
                elig[i] = vld_vec[i] && !isd_vec[i] && rdy_vec[i]
                          && (ent_q[i].cls == op_cls_e'(CLS_W'(c)));
        end
        uopq_oldest_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
            .elig  (elig),
            .head  (head_q),
            .found (pick_found[c]),
            .idx   (pick_idx[c])
        );
        assign iss_valid[c]                  = pick_found[c] && !flush;
        assign iss_idx[c*IDX_W +: IDX_W]     = pick_idx[c];
        assign iss_data[c*DATA_W +: DATA_W]  = data_q[pick_idx[c]];
    end

    uopq_retire_scan #(.DEPTH(DEPTH), .GRP(GRP), .IDX_W(IDX_W), .GCNT_W(GCNT_W)) u_ret (
        .fin   (done_vec),
        .head  (head_q),
        .block (flush),
        .mask  (ret_mask),
        .count (ret_n)
    );

    assign ret_valid = ret_mask;
    for (genvar k = 0; k < GRP; k++) begin : g_ret
        assign ret_data[k*DATA_W +: DATA_W] = data_q[IDX_W'(ring_add(int'(head_q), k, DEPTH))];
    end

    // space freed by this cycle's retirement counts toward acceptance
    assign in_ready = !flush && (int'(in_count) <= GRP)
                      && (int'(in_count) <= int'(free_q) + int'(ret_n));
    assign alloc    = in_valid && in_ready;
    assign alloc_n  = alloc ? in_count : '0;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q <= '0;
            tail_q <= '0;
            free_q <= CNT_W'(DEPTH);
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            if (wake_valid && vld_vec[wake_idx]) ent_q[wake_idx].rdy <= 1'b1;
            for (int c = 0; c < NUM_CLS; c++)
                if (iss_valid[c]) ent_q[pick_idx[c]].issued <= 1'b1;
            for (int j = 0; j < CMP_N; j++)
                if (cmp_valid[j] && vld_vec[cmp_idx[j*IDX_W +: IDX_W]])
                    ent_q[cmp_idx[j*IDX_W +: IDX_W]].done <= 1'b1;
            // retire clears first; allocation below may reuse the same slot
            for (int k = 0; k < GRP; k++)
                if (ret_mask[k]) ent_q[IDX_W'(ring_add(int'(head_q), k, DEPTH))] <= '0;
            for (int k = 0; k < GRP; k++) begin
                if (alloc && k < int'(in_count)) begin
                    ent_q[IDX_W'(ring_add(int'(tail_q), k, DEPTH))] <= '{
                        valid: 1'b1, issued: 1'b0, rdy: in_rdy[k], done: 1'b0,
                        cls: op_cls_e'(in_cls[k*CLS_W +: CLS_W])};
                    data_q[IDX_W'(ring_add(int'(tail_q), k, DEPTH))] <= in_data[k*DATA_W +: DATA_W];
                end
            end
            head_q <= IDX_W'(ring_add(int'(head_q), int'(ret_n), DEPTH));
            tail_q <= IDX_W'(ring_add(int'(tail_q), int'(alloc_n), DEPTH));
            free_q <= CNT_W'(int'(free_q) + int'(ret_n) - int'(alloc_n));
        end
    end
endmodule

// File: rtl/uopq_sched_checker.sv
`timescale 1ns/1ps
module uopq_sched_checker #(
    parameter int DEPTH  = 24,
    parameter int GRP    = 4,
    parameter int NCLS   = 6,
    parameter int CMP_N  = 6,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 5,
    parameter int GCNT_W = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    flush,
    input logic                    in_valid,
    input logic [GCNT_W-1:0]       in_count,
    input logic                    in_ready,
    input logic [NCLS-1:0]         iss_valid,
    input logic [NCLS*IDX_W-1:0]   iss_idx,
    input logic [CMP_N-1:0]        cmp_valid,
    input logic [CMP_N*IDX_W-1:0]  cmp_idx,
    input logic [GRP-1:0]          ret_valid,
    input logic [CNT_W-1:0]        free_q,
    input logic [GCNT_W-1:0]       ret_n,
    input logic [IDX_W-1:0]        head_q,
    input logic [IDX_W-1:0]        tail_q,
    input logic [DEPTH-1:0]        vld_vec,
    input logic [DEPTH-1:0]        isd_vec,
    input logic [DEPTH-1:0]        rdy_vec,
    input logic [DEPTH-1:0]        done_vec
);
    assert_free_bound_R3: assert property (@(posedge clk) disable iff (rst)
        int'(free_q) <= DEPTH);

    assert_accept_fits_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> (int'(in_count) <= GRP && int'(in_count) <= int'(free_q) + int'(ret_n)));

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (iss_valid == '0 && ret_valid == '0 && int'(free_q) == DEPTH));

    assert_alloc_at_tail_R6: assert property (@(posedge clk) disable iff (rst || flush)
        (in_valid && in_ready && in_count != '0) |=> vld_vec[$past(tail_q)]);

    assert_head_finished_R8: assert property (@(posedge clk) disable iff (rst)
        ret_valid[0] |-> done_vec[head_q]);

    for (genvar k = 1; k < GRP; k++) begin : g_rc
        assert_retire_contig_R8: assert property (@(posedge clk) disable iff (rst)
            ret_valid[k] |-> ret_valid[k-1]);
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_ic
        assert_issue_eligible_R4: assert property (@(posedge clk) disable iff (rst)
            iss_valid[c] |-> (vld_vec[iss_idx[c*IDX_W +: IDX_W]] && !isd_vec[iss_idx[c*IDX_W +: IDX_W]]
                              && rdy_vec[iss_idx[c*IDX_W +: IDX_W]]));
        assert_no_reissue_R5: assert property (@(posedge clk) disable iff (rst || flush)
            iss_valid[c] |=> !(iss_valid[c] && iss_idx[c*IDX_W +: IDX_W] == $past(iss_idx[c*IDX_W +: IDX_W])));
    end

    for (genvar j = 0; j < CMP_N; j++) begin : g_cc
        assert_completion_marks_R7: assert property (@(posedge clk) disable iff (rst || flush)
            (cmp_valid[j] && vld_vec[cmp_idx[j*IDX_W +: IDX_W]]) |=> done_vec[$past(cmp_idx[j*IDX_W +: IDX_W])]);
    end
endmodule

bind uop_sched_buf uopq_sched_checker #(
    .DEPTH(DEPTH), .GRP(GRP), .NCLS(uopq_pkg::NUM_CLS), .CMP_N(CMP_N),
    .IDX_W(IDX_W), .CNT_W(CNT_W), .GCNT_W(GCNT_W)
) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_count(in_count),
    .in_ready(in_ready), .iss_valid(iss_valid), .iss_idx(iss_idx),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .ret_valid(ret_valid),
    .free_q(free_q), .ret_n(ret_n), .head_q(head_q), .tail_q(tail_q),
    .vld_vec(vld_vec), .isd_vec(isd_vec), .rdy_vec(rdy_vec), .done_vec(done_vec)
);

// File: tb/uop_sched_buf_test.sv
`timescale 1ns/1ps
module uop_sched_buf_test;
    logic        clk = 1'b0;
    logic        rst, flush, in_valid, wake_valid;
    logic [2:0]  in_count;
    logic [11:0] in_cls;
    logic [3:0]  in_rdy;
    logic [31:0] in_data;
    logic [4:0]  wake_idx;
    logic [5:0]  cmp_valid;
    logic [29:0] cmp_idx;
    logic        in_ready;
    logic [5:0]  iss_valid;
    logic [29:0] iss_idx;
    logic [47:0] iss_data;
    logic [3:0]  ret_valid;
    logic [31:0] ret_data;

    always #10 clk = ~clk;

    uop_sched_buf uut (
        .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_count(in_count),
        .in_cls(in_cls), .in_rdy(in_rdy), .in_data(in_data), .in_ready(in_ready),
        .wake_valid(wake_valid), .wake_idx(wake_idx), .iss_valid(iss_valid),
        .iss_idx(iss_idx), .iss_data(iss_data), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
        .ret_valid(ret_valid), .ret_data(ret_data)
    );

    typedef struct { int idx; int cls; bit rdy; bit isd; bit dn; int dat; } mop_t;
    mop_t mq[$];
    int   pend[$];
    int   mtail = 0;
    int   nchecks = 0, nfail = 0;
    bit   finished = 0;
    int   e_rn;
    bit   e_ready;
    bit   e_iv[6];
    int   e_idx[6];
    int   e_dat[6];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic idle();
        flush = 0; in_valid = 0; in_count = 0; in_cls = 0; in_rdy = 0; in_data = 0;
        wake_valid = 0; wake_idx = 0; cmp_valid = 0; cmp_idx = 0;
    endtask

    task automatic model_expect();
        e_rn = 0;
        if (!flush) while (e_rn < 4 && e_rn < mq.size() && mq[e_rn].dn) e_rn++;
        e_ready = !flush && in_count <= 4 && int'(in_count) <= 24 - mq.size() + e_rn;
        for (int c = 0; c < 6; c++) begin
            e_iv[c] = 0; e_idx[c] = 0; e_dat[c] = 0;
            if (!flush) begin
                for (int i = 0; i < mq.size(); i++) begin
                    if (mq[i].cls == c && mq[i].rdy && !mq[i].isd) begin
                        e_iv[c] = 1; e_idx[c] = mq[i].idx; e_dat[c] = mq[i].dat;
                        break;
                    end
                end
            end
        end
    endtask

    task automatic compare();
        chk(in_ready === e_ready, "R2", "in_ready", int'(in_ready), int'(e_ready));
        for (int c = 0; c < 6; c++) begin
            chk(iss_valid[c] === e_iv[c], "R4", "iss_valid", int'(iss_valid[c]), int'(e_iv[c]));
            if (e_iv[c] && iss_valid[c]) begin
                chk(int'(iss_idx[c*5 +: 5]) == e_idx[c], "R6", "issue tag", int'(iss_idx[c*5 +: 5]), e_idx[c]);
                chk(int'(iss_data[c*8 +: 8]) == e_dat[c], "R5", "issue payload", int'(iss_data[c*8 +: 8]), e_dat[c]);
            end
        end
        for (int k = 0; k < 4; k++) begin
            chk(ret_valid[k] === (k < e_rn), "R8", "ret_valid", int'(ret_valid[k]), int'(k < e_rn));
            if (k < e_rn && ret_valid[k])
                chk(int'(ret_data[k*8 +: 8]) == mq[k].dat, "R7", "ret_data", int'(ret_data[k*8 +: 8]), mq[k].dat);
        end
    endtask

    task automatic model_update();
        if (rst || flush) begin
            mq.delete(); pend.delete(); mtail = 0;
            return;
        end
        if (wake_valid)
            for (int i = 0; i < mq.size(); i++) if (mq[i].idx == int'(wake_idx)) mq[i].rdy = 1;
        for (int c = 0; c < 6; c++)
            if (e_iv[c])
                for (int i = 0; i < mq.size(); i++)
                    if (mq[i].idx == e_idx[c]) begin mq[i].isd = 1; pend.push_back(e_idx[c]); end
        for (int j = 0; j < 6; j++)
            if (cmp_valid[j])
                for (int i = 0; i < mq.size(); i++) if (mq[i].idx == int'(cmp_idx[j*5 +: 5])) mq[i].dn = 1;
        for (int k = 0; k < e_rn; k++) void'(mq.pop_front());
        if (in_valid && e_ready)
            for (int k = 0; k < int'(in_count); k++) begin
                mq.push_back('{idx: mtail, cls: int'(in_cls[k*3 +: 3]), rdy: in_rdy[k],
                               isd: 0, dn: 0, dat: int'(in_data[k*8 +: 8])});
                mtail = (mtail + 1) % 24;
            end
    endtask

    task automatic cycle();
        #1;
        if (!rst) begin model_expect(); compare(); end
        @(posedge clk);
        if (rst) model_update(); else model_update();
        @(negedge clk);
    endtask

    task automatic fill_blocked(int groups);
        for (int g = 0; g < groups; g++) begin
            idle();
            in_valid = 1; in_count = 4;
            for (int k = 0; k < 4; k++) begin
                in_cls[k*3 +: 3]  = 3'((mtail + k) % 6);
                in_data[k*8 +: 8] = 8'(mtail + k + 16);
            end
            cycle();
        end
        idle();
    endtask

    task automatic rand_stim();
        idle();
        if ($urandom_range(0, 99) == 0) flush = 1;
        if ($urandom_range(0, 99) < 60) begin
            in_valid = 1;
            in_count = ($urandom_range(0, 19) == 0) ? 3'd5 : 3'($urandom_range(1, 4));
            for (int k = 0; k < 4; k++) begin
                in_cls[k*3 +: 3]  = 3'($urandom_range(0, 5));
                in_rdy[k]         = 1'($urandom_range(0, 1));
                in_data[k*8 +: 8] = 8'($urandom_range(0, 255));
            end
        end
        if (mq.size() > 0 && $urandom_range(0, 99) < 60) begin
            int p = $urandom_range(0, mq.size() - 1);
            wake_valid = 1; wake_idx = 5'(mq[p].idx);
        end
        for (int j = 0; j < 6; j++) begin
            if (pend.size() > 0 && $urandom_range(0, 99) < 50) begin
                int p = $urandom_range(0, pend.size() - 1);
                cmp_valid[j] = 1; cmp_idx[j*5 +: 5] = 5'(pend[p]);
                pend.delete(p);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL R1 watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

    initial begin
        idle(); rst = 1;
        @(negedge clk);
        repeat (3) cycle();
        rst = 0;

        // R1: empty after reset
        in_count = 4; #1;
        chk(in_ready == 1, "R1", "in_ready after reset", int'(in_ready), 1);
        chk(iss_valid == 0, "R1", "iss_valid after reset", int'(iss_valid), 0);
        chk(ret_valid == 0, "R1", "ret_valid after reset", int'(ret_valid), 0);
        cycle();

        // R3: fill to capacity with blocked ops, then one more is refused
        fill_blocked(6);
        in_valid = 1; in_count = 1; #1;
        chk(in_ready == 0, "R3", "full buffer refuses", int'(in_ready), 0);
        cycle(); idle();

        // R4: wakeup makes entry 5 (class 5) eligible next cycle
        wake_valid = 1; wake_idx = 5; #1;
        chk(iss_valid == 0, "R4", "no issue before wake", int'(iss_valid), 0);
        cycle(); idle(); #1;
        chk(iss_valid == 6'b100000 && iss_idx[25 +: 5] == 5, "R4", "woken entry issues", int'(iss_idx[25 +: 5]), 5);
        cycle();
        cmp_valid = 6'b000001; cmp_idx[4:0] = 5; cycle(); idle(); #1;
        chk(ret_valid == 0, "R8", "unfinished head blocks", int'(ret_valid), 0);
        cycle();

        // R10: flush
        flush = 1; in_valid = 1; in_count = 1; #1;
        chk(in_ready == 0, "R10", "no accept during flush", int'(in_ready), 0);
        cycle(); idle(); in_count = 4; #1;
        chk(in_ready == 1 && iss_valid == 0 && ret_valid == 0, "R10", "empty after flush", int'(in_ready), 1);
        cycle();

        // R5, R11, R7: oldest-first per class, issue/retire latency
        in_valid = 1; in_count = 4; in_rdy = 4'b1111;
        in_cls = {3'd3, 3'd2, 3'd2, 3'd2}; in_data = {8'd203, 8'd202, 8'd201, 8'd200}; #1;
        chk(iss_valid == 0, "R11", "no issue in enqueue cycle", int'(iss_valid), 0);
        cycle(); idle(); #1;
        chk(iss_valid == 6'b001100 && iss_idx[10 +: 5] == 0 && iss_idx[15 +: 5] == 3, "R5",
            "oldest per class", int'(iss_idx[10 +: 5]), 0);
        cycle();
        cmp_valid = 6'b000011; cmp_idx[4:0] = 0; cmp_idx[9:5] = 3; #1;
        chk(ret_valid == 0, "R11", "no retire in completion cycle", int'(ret_valid), 0);
        cycle(); idle();
        cmp_valid = 6'b000001; cmp_idx[4:0] = 1; #1;
        chk(ret_valid == 4'b0001 && ret_data[7:0] == 200, "R7", "head retires payload", int'(ret_data[7:0]), 200);
        cycle(); idle();
        cmp_valid = 6'b000001; cmp_idx[4:0] = 2; cycle(); idle(); #1;
        chk(ret_valid == 4'b0011, "R8", "two finished retire together", int'(ret_valid), 3);
        cycle();
        repeat (3) cycle();

        // R9: full buffer, head retiring, new op accepted in same cycle
        flush = 1; cycle(); idle();
        fill_blocked(6);
        wake_valid = 1; wake_idx = 0; cycle(); idle();
        cycle();
        cmp_valid = 6'b000001; cmp_idx[4:0] = 0; cycle(); idle();
        in_valid = 1; in_count = 1; in_data[7:0] = 8'd99; #1;
        chk(ret_valid == 4'b0001 && in_ready == 1, "R9", "reuse retiring slot", int'(in_ready), 1);
        cycle(); idle();
        in_valid = 1; in_count = 1; #1;
        chk(in_ready == 0, "R3", "full again after reuse", int'(in_ready), 0);
        cycle(); idle();
        flush = 1; cycle(); idle();

        // random traffic compared against the queue model every cycle
        for (int n = 0; n < 3000; n++) begin
            rand_stim();
            cycle();
        end
        idle();
        repeat (4) cycle();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end
endmodule